// File: doc/BRIEF.md
# Per-Pixel Depth Test and Store Enable Unit

This block sits in a raster pipeline after the depth interpolator and before the memory write port. For each pixel, it compares the incoming depth against the depth already stored at that location. A two-bit function code selects the comparison. A separate two-bit policy code then decides whether the colour store and the depth store are written. The policies keep the frame update apart from the depth update. One policy tests the pixel but leaves the stored depth untouched. Another writes colour without any depth traffic.

A bypass bit forces the comparison to pass. Comparisons are unsigned, and the depth width is a parameter. The decision is registered, so both store enables and an output valid flag appear exactly one clock after the input strobe.

Top module: `zt_gate`

## Requirements
- R1: Function code 2'b00 passes when the new depth is greater than or equal to the stored depth (unsigned).
- R2: Function code 2'b10 passes when the new depth is less than the stored depth; 2'b01 passes when the new depth is greater than the stored depth.
- R3: Function code 2'b11 passes only when the new depth equals the stored depth.
- R4: When `bypass_cmp` is 1, the test passes whatever the depth values and the function code.
- R5: Policy 2'b00 raises both `frame_we` and `depth_we` only when the test passes, and neither otherwise.
- R6: Policy 2'b01 raises `frame_we` when the test passes and never raises `depth_we`.
- R7: Policy 2'b10 raises both enables whatever the test result.
- R8: Policy 2'b11 raises `frame_we` always and never raises `depth_we`.
- R9: Outputs appear one clock after the input. `out_vld` equals the previous cycle's `pix_vld`, and both enables are 0 whenever `out_vld` is 0.
- R10: A synchronous active-high `rst` clears `out_vld`, `frame_we` and `depth_we` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vld | input | 1 | Pixel present this cycle |
| z_new | input | ZW | Incoming depth |
| z_old | input | ZW | Stored depth |
| cmp_fn | input | 2 | Comparison function code |
| bypass_cmp | input | 1 | Force test pass |
| wr_policy | input | 2 | Store write policy |
| out_vld | output | 1 | Decision valid (one cycle after pix_vld) |
| frame_we | output | 1 | Colour store write enable |
| depth_we | output | 1 | Depth store write enable |

## Verification
Each function code is driven with three depth pairs: new below, equal to, and above the stored value. This separates the greater-equal code from strict greater and equal-only, and the less-than code from its complement. The extremes 0 and all-ones expose any signed or truncated comparison. Every policy is applied to both a passing and a failing pixel, so a mode that ignores the test can be told apart from one that follows it. Bypass is applied to failing pairs. Gaps in the valid strobe and a mid-stream reset check that nothing leaks into idle cycles.

// File: rtl/zt_pkg.sv
package zt_pkg;
   typedef enum logic [1:0] {
      FN_GE = 2'b00,
      FN_GT = 2'b01,
      FN_LT = 2'b10,
      FN_EQ = 2'b11
   } zt_fn_e;

   typedef enum logic [1:0] {
      WP_TESTED = 2'b00,
      WP_KEEPZ  = 2'b01,
      WP_FORCE  = 2'b10,
      WP_COLOR  = 2'b11
   } zt_policy_e;

   typedef struct packed {
      logic vld;
      logic fwe;
      logic zwe;
   } zt_out_t;
endpackage

// File: rtl/zt_compare.sv
module zt_compare #(
   parameter int ZW        = 24,
   parameter bit CMP_SPLIT = 1'b1
) (
   input  logic [ZW-1:0] z_new,
   input  logic [ZW-1:0] z_old,
   input  logic [1:0]    fn,
   input  logic          bypass,
   output logic          pass
);
   import zt_pkg::*;

   initial begin
      if (ZW < 1) $error("zt_compare: ZW must be positive");
   end

   logic lt, eq;

   generate
      if (CMP_SPLIT) begin : g_split
         // Magnitude and equality come from separate comparators.
         assign lt = (z_new < z_old);
         assign eq = (z_new == z_old);
      end else begin : g_sub
         // Magnitude comes from the borrow of a subtraction.
         logic [ZW:0] diff;
         assign diff = {1'b0, z_new} - {1'b0, z_old};
         assign lt   = diff[ZW];
         assign eq   = (diff[ZW-1:0] == '0) && !diff[ZW];
      end
   endgenerate

   logic raw;
   always_comb begin
      unique case (zt_fn_e'(fn))
         FN_GE:   raw = !lt;
         FN_GT:   raw = !lt && !eq;
         FN_LT:   raw = lt;
         FN_EQ:   raw = eq;
         default: raw = 1'b0;
      endcase
   end

   assign pass = bypass | raw;
endmodule

// File: rtl/zt_policy.sv
module zt_policy (
   input  logic       vld,
   input  logic       pass,
   input  logic [1:0] policy,
   output logic       fwe,
   output logic       zwe
);
   import zt_pkg::*;

   logic f, z;
   always_comb begin
      unique case (zt_policy_e'(policy))
         WP_TESTED: begin f = pass; z = pass; end
         WP_KEEPZ:  begin f = pass; z = 1'b0; end
         WP_FORCE:  begin f = 1'b1; z = 1'b1; end
         WP_COLOR:  begin f = 1'b1; z = 1'b0; end
         default:   begin f = 1'b0; z = 1'b0; end
      endcase
   end

   assign fwe = vld & f;
   assign zwe = vld & z;
endmodule

// File: rtl/zt_gate.sv
module zt_gate #(
   parameter int ZW        = 24,
   parameter bit CMP_SPLIT = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          pix_vld,
   input  logic [ZW-1:0] z_new,
   input  logic [ZW-1:0] z_old,
   input  logic [1:0]    cmp_fn,
   input  logic          bypass_cmp,
   input  logic [1:0]    wr_policy,
   output logic          out_vld,
   output logic          frame_we,
   output logic          depth_we
);
   import zt_pkg::*;

   localparam int ZMAX = ZW;

   initial begin
      if (ZMAX < 1 || ZMAX > 64) $error("zt_gate: ZW out of range");
   end

   logic    pass, fwe_c, zwe_c;
   zt_out_t q;

   zt_compare #(.ZW(ZW), .CMP_SPLIT(CMP_SPLIT)) u_cmp (
      .z_new (z_new),
      .z_old (z_old),
      .fn    (cmp_fn),
      .bypass(bypass_cmp),
      .pass  (pass)
   );

   zt_policy u_pol (
      .vld   (pix_vld),
      .pass  (pass),
      .policy(wr_policy),
      .fwe   (fwe_c),
      .zwe   (zwe_c)
   );

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= '{vld: pix_vld, fwe: fwe_c, zwe: zwe_c};
   end

   assign out_vld  = q.vld;
   assign frame_we = q.fwe;
   assign depth_we = q.zwe;

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !out_vld |-> (!frame_we && !depth_we));

   // R9
   vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_vld == $past(pix_vld)));

   // R6
   keepz_chk: assert property (@(posedge clk) disable iff (rst)
      (pix_vld && wr_policy == 2'b01) |=> !depth_we);

   // R7
   force_chk: assert property (@(posedge clk) disable iff (rst)
      (pix_vld && wr_policy == 2'b10) |=> (frame_we && depth_we));

   // R8
   color_chk: assert property (@(posedge clk) disable iff (rst)
      (pix_vld && wr_policy == 2'b11) |=> (frame_we && !depth_we));

   // R4
   bypass_chk: assert property (@(posedge clk) disable iff (rst)
      (pix_vld && bypass_cmp && wr_policy == 2'b00) |=> (frame_we && depth_we));

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_vld && !frame_we && !depth_we));
endmodule

// File: tb/zt_gate_bench.sv
module zt_gate_bench;
   localparam int ZW = 8;

   logic          clk = 1'b0;
   logic          rst;
   logic          pix_vld;
   logic [ZW-1:0] z_new, z_old;
   logic [1:0]    cmp_fn, wr_policy;
   logic          bypass_cmp;
   logic          out_vld, frame_we, depth_we;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   typedef struct {
      logic       v;
      logic       f;
      logic       z;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   zt_gate #(.ZW(ZW)) u_zt_gate (
      .clk(clk), .rst(rst), .pix_vld(pix_vld), .z_new(z_new), .z_old(z_old),
      .cmp_fn(cmp_fn), .bypass_cmp(bypass_cmp), .wr_policy(wr_policy),
      .out_vld(out_vld), .frame_we(frame_we), .depth_we(depth_we)
   );

   function automatic logic ref_pass(logic [ZW-1:0] a, logic [ZW-1:0] b,
                                     logic [1:0] fn, logic byp);
      if (byp) return 1'b1;
      case (fn)
         2'b00:   return a >= b;
         2'b10:   return a < b;
         2'b01:   return a > b;
         default: return a == b;
      endcase
   endfunction

   // Drive one cycle (inputs change on the falling edge) and queue the expectation.
   task automatic drive(logic v, logic [ZW-1:0] a, logic [ZW-1:0] b,
                        logic [1:0] fn, logic byp, logic [1:0] pol, string tag);
      logic p, f, z;
      @(negedge clk);
      pix_vld = v; z_new = a; z_old = b; cmp_fn = fn; bypass_cmp = byp; wr_policy = pol;
      p = ref_pass(a, b, fn, byp);
      case (pol)
         2'b00:   begin f = p;    z = p;    end
         2'b01:   begin f = p;    z = 1'b0; end
         2'b10:   begin f = 1'b1; z = 1'b1; end
         default: begin f = 1'b1; z = 1'b0; end
      endcase
      sb.push_back('{v, v & f, v & z, tag});
   endtask

   // Monitor: one expectation per cycle, compared at the falling edge after the capture edge.
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0 && !rst) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (out_vld !== e.v || frame_we !== e.f || depth_we !== e.z) begin
               n_fail++;
               $display("FAIL %s: got v=%b f=%b z=%b exp v=%b f=%b z=%b",
                        e.tag, out_vld, frame_we, depth_we, e.v, e.f, e.z);
            end
         end
      end
   end

   task automatic chk_reset(string tag);
      n_run++;
      if (out_vld !== 1'b0 || frame_we !== 1'b0 || depth_we !== 1'b0) begin
         n_fail++;
         $display("FAIL %s: got v=%b f=%b z=%b exp 000", tag, out_vld, frame_we, depth_we);
      end
   endtask

   initial begin
      rst = 1; pix_vld = 0; z_new = 0; z_old = 0; cmp_fn = 0; bypass_cmp = 0; wr_policy = 0;
      repeat (3) @(negedge clk);
      chk_reset("R10 reset state");
      rst = 0;
      // R1 R2 R3 R5: every function code with below, equal and above pairs
      for (int fn = 0; fn < 4; fn++) begin
         drive(1, 8'd10, 8'd20, fn[1:0], 0, 2'b00, "R1/R2/R3/R5 below");
         drive(1, 8'd20, 8'd20, fn[1:0], 0, 2'b00, "R1/R2/R3/R5 equal");
         drive(1, 8'd30, 8'd20, fn[1:0], 0, 2'b00, "R1/R2/R3/R5 above");
         drive(1, 8'hFF, 8'h00, fn[1:0], 0, 2'b00, "R1/R2/R3 extreme hi");
         drive(1, 8'h00, 8'hFF, fn[1:0], 0, 2'b00, "R1/R2/R3 extreme lo");
      end
      // R4: bypass on failing pairs
      drive(1, 8'd5, 8'd9, 2'b11, 1, 2'b00, "R4 bypass eq");
      drive(1, 8'd9, 8'd5, 2'b10, 1, 2'b00, "R4 bypass lt");
      // R5 R6 R7 R8: each policy with pass and fail
      for (int pol = 0; pol < 4; pol++) begin
         drive(1, 8'd7, 8'd7, 2'b11, 0, pol[1:0], "R5/R6/R7/R8 pass");
         drive(1, 8'd7, 8'd8, 2'b11, 0, pol[1:0], "R5/R6/R7/R8 fail");
      end
      // R9: gaps in the strobe
      drive(0, 8'd1, 8'd1, 2'b11, 1, 2'b10, "R9 idle");
      drive(1, 8'd1, 8'd1, 2'b11, 0, 2'b10, "R9 active");
      drive(0, 8'd1, 8'd1, 2'b00, 0, 2'b11, "R9 idle");
      drive(0, 8'd1, 8'd1, 2'b00, 0, 2'b11, "R9 idle 2");
      @(negedge clk);
      pix_vld = 0;
      repeat (3) @(negedge clk);
      // R10: reset mid-stream
      pix_vld = 1; wr_policy = 2'b10; rst = 1;
      @(negedge clk);
      chk_reset("R10 reset mid-stream");
      pix_vld = 0; rst = 0;
      @(negedge clk);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule